// File: doc/BRIEF.md
# Two-Wire Serial Slave Memory

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that holds a 2048-byte memory. A system clock much faster than SCL oversamples both lines. The block finds start and stop conditions and shifts bytes in and out. It answers only to control bytes whose device-type field matches its own.

The slave uses a single 11-bit pointer. A write operation loads the pointer from two sources:
- the page-select field of the control byte, as the upper three bits;
- a word-address byte, as the lower eight bits.

The write then stores any number of data bytes at successive addresses. A read operation sends no word address. It replaces only the page bits of the pointer and streams bytes from there until the master withholds its acknowledge.

The slave never drives SDA high. Its single output is an active-high enable that pulls the wired-AND line low.

The block has no streaming data port. Every byte moves over the two bus wires, so no valid/ready back-pressure applies at its edge. The bus master sets the pace through SCL.

Top module: `twowire_mem_slave`

## Requirements
- R1: The control byte after a start carries a device type in bits 7..4, a page select in bits 3..1 and a direction flag in bit 0 (1 = master reads). When bits 7..4 equal the device-type parameter (default binary 1010), the slave pulls SDA low during the ninth clock.
- R2: When the device type does not match, the slave acknowledges neither that byte nor any later byte until the next start, and it writes no memory location.
- R3: In a write operation, the byte after the control byte is a word address. The slave acknowledges it, and each following data byte is stored at address {page, word} and then at successive addresses. The slave acknowledges every data byte.
- R4: A read operation sends no word address. The page select replaces bits 10..8 of the pointer, and bits 7..0 keep their previous value.
- R5: The pointer advances by one for each data byte, before that byte's acknowledge clock. From 0x7FF it wraps to 0x000.
- R6: A transfer may start at any address and may move any number of bytes. It continues across 256-byte page boundaries.
- R7: Read data leaves the slave most significant bit first. The slave releases SDA on the ninth clock. An acknowledge from the master fetches the next byte. A missing acknowledge ends the read, and SDA stays released.
- R8: The slave only pulls SDA low and never drives it high. Its drive changes only while SCL is low.
- R9: A stop condition aborts the operation at any point. After a stop, the slave ignores the bus until the next start. A repeated start ends the current operation and begins a new control byte.
- R10: After reset, the slave does not drive SDA and waits for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench builds the block with its default parameters:
- device type 1010;
- three page bits;
- eight-bit words, which give the full 11-bit space;
- two synchronizer stages.

With these values, a three-byte write at page 7, word 0xFE reaches the 0x7FF-to-0x000 wrap. A two-byte write at page 1, word 0xFF crosses a page boundary. Ten system clocks per quarter SCL period leave the synchronizer delay well inside each bus phase, so the slave's drive changes can be observed while SCL is low.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } twm_state_e;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/twm_addr_latch.sv
module twm_addr_latch #(
  parameter int PAGE_W = 3,
  parameter int WORD_W = 8,
  localparam int ADDR_W = PAGE_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_page_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              ld_word_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (ld_page_i) addr_q[ADDR_W-1:WORD_W] <= page_i;
    else if (ld_word_i) addr_q[WORD_W-1:0] <= word_i;
    else if (inc_i)     addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  // R5: the top address rolls over to zero
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_page_i && !ld_word_i && addr_q == '1) |=> addr_q == '0)
    else $error("pointer did not wrap");

  // R4: loading a page leaves the low word untouched
  p_page_keeps_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_page_i |=> addr_q[WORD_W-1:0] == $past(addr_q[WORD_W-1:0]))
    else $error("page load disturbed low bits");

  // R3: a word load keeps the page bits
  p_word_keeps_page_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_word_i && !ld_page_i) |=> addr_q[ADDR_W-1:WORD_W] == $past(addr_q[ADDR_W-1:WORD_W]))
    else $error("word load disturbed page bits");
endmodule

// File: rtl/twm_byte_store.sv
module twm_byte_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[addr_i] <= wdata_i;
  end

  assign rdata_o = cells[addr_i];
endmodule

// File: rtl/twm_bus_fsm.sv
module twm_bus_fsm
  import twm_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010,
  parameter int          PAGE_W = 3,
  parameter int          WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              ld_page_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              ld_word_o,
  output logic [WORD_W-1:0] word_o,
  output logic              inc_o,
  output logic              we_o,
  output logic [WORD_W-1:0] wdata_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(WORD_W + 1);

  twm_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic              sda_oe_q;
  logic              rd_mode_q;
  logic              mnack_q;

  logic start_c, stop_c, live, byte_end, ack_end, id_ok, load_rd;

  // bus conditions from synchronized levels: SDA edge while SCL held high
  assign start_c  = scl_lvl_i & ~scl_rise_i & sda_fall_i;
  assign stop_c   = scl_lvl_i & ~scl_rise_i & sda_rise_i;
  assign live     = (state_q != ST_IDLE) & ~start_c & ~stop_c;
  assign byte_end = live & scl_fall_i & (cnt_q == CNT_DATA);
  assign ack_end  = live & scl_fall_i & (cnt_q == CNT_ACK);
  assign id_ok    = (shreg_q[WORD_W-1 -: 4] == DEV_ID);
  assign load_rd  = ack_end & (((state_q == ST_CTRL) & rd_mode_q) |
                               ((state_q == ST_RDATA) & ~mnack_q));

  assign ld_page_o = byte_end & (state_q == ST_CTRL) & id_ok;
  assign page_o    = shreg_q[PAGE_W:1];
  assign ld_word_o = byte_end & (state_q == ST_WADDR);
  assign word_o    = shreg_q;
  assign we_o      = byte_end & (state_q == ST_WDATA);
  assign wdata_o   = shreg_q;
  assign inc_o     = we_o | load_rd;
  assign sda_oe_o  = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      sda_oe_q  <= 1'b0;
      rd_mode_q <= 1'b0;
      mnack_q   <= 1'b1;
    end else if (stop_c) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (start_c) begin
      state_q  <= ST_CTRL;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (live) begin
      if (scl_rise_i) begin
        if (cnt_q < CNT_DATA) begin
          cnt_q <= cnt_q + 1'b1;
          if (state_q != ST_RDATA) shreg_q <= {shreg_q[WORD_W-2:0], sda_lvl_i};
        end else if (cnt_q == CNT_DATA) begin
          cnt_q   <= CNT_ACK;
          mnack_q <= sda_lvl_i;
        end
      end else if (byte_end) begin
        case (state_q)
          ST_CTRL: begin
            rd_mode_q <= shreg_q[0];
            if (id_ok) sda_oe_q <= 1'b1;
            else       state_q  <= ST_IDLE;
          end
          ST_RDATA: sda_oe_q <= 1'b0;
          default:  sda_oe_q <= 1'b1;
        endcase
      end else if (ack_end) begin
        cnt_q <= '0;
        if (load_rd) begin
          state_q  <= ST_RDATA;
          shreg_q  <= rdata_i;
          sda_oe_q <= ~rdata_i[WORD_W-1];
        end else begin
          sda_oe_q <= 1'b0;
          case (state_q)
            ST_CTRL:  state_q <= ST_WADDR;
            ST_WADDR: state_q <= ST_WDATA;
            ST_RDATA: state_q <= ST_IDLE;
            default:  state_q <= state_q;
          endcase
        end
      end else if (scl_fall_i && state_q == ST_RDATA && cnt_q != '0) begin
        shreg_q  <= {shreg_q[WORD_W-2:0], 1'b0};
        sda_oe_q <= ~shreg_q[WORD_W-2];
      end
    end
  end

  // R9: a stop always returns to idle with SDA released
  p_stop_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_c |=> (state_q == ST_IDLE && !sda_oe_q))
    else $error("stop did not abort");

  // R2: a foreign device type is never acknowledged
  p_no_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && state_q == ST_CTRL && !id_ok) |=> (state_q == ST_IDLE && !sda_oe_q))
    else $error("foreign control byte acknowledged");

  // R8: drive changes only after an SCL fall or a bus condition
  p_drive_on_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_q) |-> $past(scl_fall_i || start_c || stop_c))
    else $error("SDA drive changed while SCL high");

  // R3: every stored byte is followed by an acknowledge
  p_write_acked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (sda_oe_q || state_q == ST_IDLE || state_q == ST_CTRL))
    else $error("write byte not acknowledged");
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int          PAGE_W      = 3,
  parameter int          WORD_W      = 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int ADDR_W = PAGE_W + WORD_W;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic              ld_page, ld_word, inc, we;
  logic [PAGE_W-1:0] page;
  logic [WORD_W-1:0] word, wdata, rdata;
  logic [ADDR_W-1:0] addr;

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  twm_bus_fsm #(.DEV_ID(DEV_ID), .PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .rdata_i(rdata), .sda_oe_o(sda_oe_o),
    .ld_page_o(ld_page), .page_o(page), .ld_word_o(ld_word), .word_o(word),
    .inc_o(inc), .we_o(we), .wdata_o(wdata)
  );

  twm_addr_latch #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_page_i(ld_page), .page_i(page), .ld_word_i(ld_word), .word_i(word),
    .inc_i(inc), .addr_o(addr)
  );

  twm_byte_store #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
    .clk_i(clk_i), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );
endmodule

// File: tb/twowire_mem_slave_tb_top.sv
module twowire_mem_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  twowire_mem_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  int drive_high_chg = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: pops expected items as read bytes arrive
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      logic [7:0] a;
      a = act_q.pop_front();
      if (exp_q.size() == 0) chk(1'b0, "R7 (unexpected byte)", a, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a == e, t, a, e);
      end
    end
  end

  // R8 observer: slave drive must not change while SCL is high
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) drive_high_chg++;
    prev_oe = sda_oe;
  end

  task automatic bus_start;
    m_sda = 1'b1; qwait(Q); scl = 1'b1; qwait(Q);
    m_sda = 1'b0; qwait(Q); scl = 1'b0; qwait(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; qwait(Q); scl = 1'b1; qwait(Q); m_sda = 1'b1; qwait(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; qwait(Q); scl = 1'b1; qwait(2 * Q); scl = 1'b0; qwait(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_sda = 1'b1; qwait(Q); scl = 1'b1; qwait(Q);
    acked = !sda_line;
    qwait(Q); scl = 1'b0; qwait(Q);
  endtask

  task automatic recv_byte(input bit give_ack, input logic [7:0] e, input string req);
    logic [7:0] b;
    m_sda = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      qwait(Q); scl = 1'b1; qwait(Q); b[i] = sda_line; qwait(Q); scl = 1'b0; qwait(Q);
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    qwait(Q); scl = 1'b1; qwait(2 * Q); scl = 1'b0; qwait(Q);
    m_sda = 1'b1;
    act_q.push_back(b);
  endtask

  task automatic put(input logic [7:0] b, input bit exp_ack, input string req);
    bit ak;
    send_byte(b, ak);
    chk(ak == exp_ack, req, ak, exp_ack);
  endtask

  task automatic open_write(input logic [2:0] pg, input logic [7:0] wa);
    bus_start;
    put({4'b1010, pg, 1'b0}, 1'b1, "R1");
    put(wa, 1'b1, "R3");
  endtask

  task automatic open_read(input logic [2:0] pg, input logic [7:0] wa);
    open_write(pg, wa);
    bus_start;                                   // repeated start, R9
    put({4'b1010, pg, 1'b1}, 1'b1, "R9");
  endtask

  initial begin
    qwait(5);
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
    rst_n = 1'b1;
    qwait(5);
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);

    // R3: sequential write at page 3 word 0x10
    open_write(3'd3, 8'h10);
    put(8'h11, 1'b1, "R3"); put(8'h22, 1'b1, "R3"); put(8'h33, 1'b1, "R3");
    bus_stop;
    open_write(3'd5, 8'h13);
    put(8'h77, 1'b1, "R3");
    bus_stop;

    // R7: random read, MSB first, ack continues, nack ends
    open_read(3'd3, 8'h10);
    recv_byte(1'b1, 8'h11, "R7");
    recv_byte(1'b1, 8'h22, "R7");
    recv_byte(1'b0, 8'h33, "R7");
    qwait(Q);
    chk(sda_oe == 1'b0, "R7", sda_oe, 0);
    bus_stop;

    // R4: current-address read, page 5 with retained low byte 0x13
    bus_start;
    put(8'b1010_101_1, 1'b1, "R1");
    recv_byte(1'b0, 8'h77, "R4");
    bus_stop;

    // R5: wrap from 0x7FF to 0x000
    open_write(3'd7, 8'hFE);
    put(8'hE1, 1'b1, "R5"); put(8'hE2, 1'b1, "R5"); put(8'hE3, 1'b1, "R5");
    bus_stop;
    open_read(3'd7, 8'hFE);
    recv_byte(1'b1, 8'hE1, "R5");
    recv_byte(1'b1, 8'hE2, "R5");
    recv_byte(1'b0, 8'hE3, "R5");
    bus_stop;

    // R6: crossing the 0x1FF/0x200 page boundary
    open_write(3'd1, 8'hFF);
    put(8'h81, 1'b1, "R6"); put(8'h82, 1'b1, "R6");
    bus_stop;
    open_read(3'd1, 8'hFF);
    recv_byte(1'b1, 8'h81, "R6");
    recv_byte(1'b0, 8'h82, "R6");
    bus_stop;

    // R2: foreign device type ignored, memory untouched
    bus_start;
    put(8'b0110_011_0, 1'b0, "R2");
    put(8'h10, 1'b0, "R2");
    put(8'h99, 1'b0, "R2");
    bus_stop;
    open_read(3'd3, 8'h10);
    recv_byte(1'b0, 8'h11, "R2");
    bus_stop;

    // R9: stop in the middle of a data byte aborts, bus ignored until start
    open_write(3'd3, 8'h20);
    put(8'h44, 1'b1, "R3"); put(8'h55, 1'b1, "R3");
    bus_stop;
    open_write(3'd3, 8'h21);
    send_bits(8'hAA, 4);
    scl = 1'b0;
    bus_stop;
    chk(sda_oe == 1'b0, "R9", sda_oe, 0);
    put(8'b1010_011_0, 1'b0, "R9");
    bus_stop;
    open_read(3'd3, 8'h20);
    recv_byte(1'b1, 8'h44, "R9");
    recv_byte(1'b0, 8'h55, "R9");
    bus_stop;

    qwait(4 * Q);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    chk(drive_high_chg == 0, "R8", drive_high_chg, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule